// File: doc/BRIEF.md
# Multicycle Predicated 16-bit Processor Core

This block is a compact 16-bit processor that talks to a single memory over one shared bus. It has a 16-bit read data input, a 16-bit write data output, a 16-bit address and a read-not-write strobe. A six-state controller runs each instruction as a fixed sequence. It fetches the instruction word and, when needed, a second operand word. It then forms an effective address. When the instruction asks for them, it reads memory, executes, or writes memory.

Every instruction carries a three-bit condition that is tested against the carry and zero flags. An instruction whose condition fails is dropped after its operand word has been consumed. The sixteen-entry register file serves as both working storage and the program counter: entry 15 is the program counter, so any instruction that writes entry 15 is a jump. Entry 0 is a constant zero.

Top module: `pred_cpu16`

## Requirements
- R1: `rst` is a synchronous, active-high reset. It clears the program counter, the carry and zero flags and the controller state. In the first cycle after reset, `bus_addr` is 0, `bus_rnw` is 1 and `bus_wdata` is 0.
- R2: `bus_rnw` is low for exactly one cycle per store, and only in the memory-write state. In that cycle `bus_addr` is the operand register and `bus_wdata` is the register named by bits [3:0]. In every other cycle `bus_wdata` is 0.
- R3: In the fetch states `bus_addr` is the program counter, and the counter increments by one for each word fetched. When instruction bit 12 is 1, a second word is fetched as the operand word.
- R4: Instruction bits are laid out as follows: bits [15:13] are the condition, bit 12 is the length bit, bits [11:8] are the opcode, bits [7:4] are the source register and bits [3:0] are the destination register. The address step loads the operand register with the source register plus the operand word when the length bit is set, and with the source register alone when it is clear.
- R5: Condition codes are 000 always, 001 carry set, 010 carry clear, 011 zero set and 100 zero clear. Codes 101, 110 and 111 never pass. A failed instruction changes no register and no flag, and fetching resumes at the word after its operand word.
- R6: Opcode bits [10:8] select the operation applied to destination register d and operand register b. 000 gives d=b. 001 gives d=d+b. 010 gives d=d&b. 011 gives d=d|b. 100 gives d=d^b. 101 is a rotate right through carry: d={C,b[15:1]} and C takes b[0]. 110 gives d=d+b+C. 111 stores d to memory at b.
- R7: Add, add-with-carry and rotate update both C and Z. AND, OR and XOR update only Z. Load and store leave both flags unchanged. Z is set when the result is 0, and C takes the carry out of bit 15.
- R8: When opcode bit 11 is set, a memory read at the operand register replaces the operand register before the operation. With a store, this gives an indirect store.
- R9: Register 0 always reads as 0, and writes to it have no effect.
- R10: Register 15 is the program counter. Writing it transfers control. Reading it as a source gives the address of the word after the last word fetched.
- R11: Cycle counts per instruction are as follows. A short operation takes 3 cycles and a long one 4. A memory operand adds 1. A store takes 4 cycles when long. A failed instruction takes 2 cycles when short and 3 when long.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_rdata | input | 16 | Data returned by memory for the current address |
| bus_wdata | output | 16 | Store data, valid while `bus_rnw` is low |
| bus_addr | output | 16 | Memory address: program counter or operand register |
| bus_rnw | output | 1 | High for read, low for the single write cycle |

## Verification
The properties assume that memory answers within the same cycle. This means `bus_rdata` must be a known value that reflects `bus_addr` whenever the controller is fetching. The bench meets this with a combinational word array that is cleared to zero before each program, so every address a program can reach returns a defined word. Programs are kept inside the modelled range, and each ends in a jump to itself so that no fetch runs past loaded code. Store results are collected from the bus at the falling edge and compared with values computed from the operation definitions.

// File: rtl/pred_cpu16_pkg.sv
package pred_cpu16_pkg;

  localparam int INSTR_W = 16;
  localparam int COND_HI = 15;
  localparam int COND_LO = 13;
  localparam int LEN_BIT = 12;
  localparam int MEM_BIT = 11;
  localparam int OPC_HI  = 10;
  localparam int OPC_LO  = 8;
  localparam int SRC_LO  = 4;
  localparam int DST_LO  = 0;

  typedef enum logic [2:0] {
    ST_FETCH0 = 3'd0,
    ST_FETCH1 = 3'd1,
    ST_EA     = 3'd2,
    ST_RDMEM  = 3'd3,
    ST_EXEC   = 3'd4,
    ST_WRMEM  = 3'd5
  } state_e;

  typedef enum logic [2:0] {
    ALU_LD  = 3'd0,
    ALU_ADD = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_XOR = 3'd4,
    ALU_ROR = 3'd5,
    ALU_ADC = 3'd6,
    ALU_STO = 3'd7
  } alu_op_e;

  // Condition evaluation; codes 5..7 never pass.
  function automatic logic cond_pass(input logic [2:0] code, input logic c, input logic z);
    case (code)
      3'd0:    return 1'b1;
      3'd1:    return c;
      3'd2:    return !c;
      3'd3:    return z;
      3'd4:    return !z;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pred_cpu16_alu.sv
module pred_cpu16_alu
  import pred_cpu16_pkg::*;
#(
  parameter int DW = 16
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic [DW-1:0] res,
  output logic          cout,
  output logic          zero,
  output logic          c_upd,
  output logic          z_upd
);

  logic          add_cin;
  logic [DW:0]   sum;

  always_comb begin
    add_cin = (op == ALU_ADC) ? cin : 1'b0;
    sum     = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, add_cin};
    res     = b;
    cout    = cin;
    c_upd   = 1'b0;
    z_upd   = 1'b0;
    case (op)
      ALU_LD: res = b;
      ALU_ADD, ALU_ADC: begin
        res   = sum[DW-1:0];
        cout  = sum[DW];
        c_upd = 1'b1;
        z_upd = 1'b1;
      end
      ALU_AND: begin res = a & b; z_upd = 1'b1; end
      ALU_OR:  begin res = a | b; z_upd = 1'b1; end
      ALU_XOR: begin res = a ^ b; z_upd = 1'b1; end
      ALU_ROR: begin
        res   = {cin, b[DW-1:1]};
        cout  = b[0];
        c_upd = 1'b1;
        z_upd = 1'b1;
      end
      default: res = a;
    endcase
    zero = (res == '0);
  end

endmodule

// File: rtl/pred_cpu16_regfile.sv
module pred_cpu16_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    pc_step,
  input  logic                    wr_en,
  input  logic [$clog2(NREG)-1:0] wr_sel,
  input  logic [DW-1:0]           wr_val,
  input  logic [$clog2(NREG)-1:0] ra_sel,
  output logic [DW-1:0]           ra_val,
  input  logic [$clog2(NREG)-1:0] rb_sel,
  output logic [DW-1:0]           rb_val,
  output logic [DW-1:0]           pc_val
);

  localparam int IW = $clog2(NREG);
  localparam logic [DW-1:0] ONE = DW'(1);

  logic [DW-1:0] bank [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    if (i == 0) begin : g_zero
      assign bank[i] = '0;
    end else if (i == NREG - 1) begin : g_pc
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)                              q <= '0;
        else if (wr_en && wr_sel == IW'(i))   q <= wr_val;
        else if (pc_step)                     q <= q + ONE;
      end
      assign bank[i] = q;
    end else begin : g_gpr
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
        if (wr_en && wr_sel == IW'(i)) q <= wr_val;
      end
      assign bank[i] = q;
    end
  end

  assign ra_val = bank[ra_sel];
  assign rb_val = bank[rb_sel];
  assign pc_val = bank[NREG-1];

endmodule

// File: rtl/pred_cpu16_ctrl.sv
module pred_cpu16_ctrl
  import pred_cpu16_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       word_len,
  input  logic [2:0] cond,
  input  logic       mem_op,
  input  alu_op_e    op,
  input  logic       c_flag,
  input  logic       z_flag,
  output state_e     state,
  output logic       pass
);

  state_e nxt;
  logic   is_store;

  assign pass     = cond_pass(cond, c_flag, z_flag);
  assign is_store = (op == ALU_STO);

  always_comb begin
    nxt = ST_FETCH0;
    case (state)
      ST_FETCH0: nxt = word_len ? ST_FETCH1 : ST_EA;
      ST_FETCH1: nxt = ST_EA;
      ST_EA: begin
        if (!pass)         nxt = ST_FETCH0;
        else if (mem_op)   nxt = ST_RDMEM;
        else if (is_store) nxt = ST_WRMEM;
        else               nxt = ST_EXEC;
      end
      ST_RDMEM: nxt = is_store ? ST_WRMEM : ST_EXEC;
      default:  nxt = ST_FETCH0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH0;
    else     state <= nxt;
  end

endmodule

// File: rtl/pred_cpu16.sv
module pred_cpu16
  import pred_cpu16_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_addr,
  output logic          bus_rnw
);

  localparam int IW = $clog2(NREG);

  state_e          st;
  logic            cond_ok;
  logic [DW-1:0]   ir_q;
  logic [DW-1:0]   opnd_q;
  logic            c_q;
  logic            z_q;
  logic [IW-1:0]   src_sel;
  logic [IW-1:0]   dst_sel;
  logic [DW-1:0]   src_val;
  logic [DW-1:0]   dst_val;
  logic [DW-1:0]   pc_val;
  alu_op_e         op;
  logic [DW-1:0]   alu_res;
  logic            alu_cout;
  logic            alu_zero;
  logic            alu_cupd;
  logic            alu_zupd;
  logic            fetching;
  logic [DW-1:0]   ea_offs;

  assign src_sel  = ir_q[SRC_LO +: IW];
  assign dst_sel  = ir_q[DST_LO +: IW];
  assign op       = alu_op_e'(ir_q[OPC_HI:OPC_LO]);
  assign fetching = (st == ST_FETCH0) || (st == ST_FETCH1);
  assign ea_offs  = ir_q[LEN_BIT] ? opnd_q : '0;

  pred_cpu16_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .word_len (bus_rdata[LEN_BIT]),
    .cond     (ir_q[COND_HI:COND_LO]),
    .mem_op   (ir_q[MEM_BIT]),
    .op       (op),
    .c_flag   (c_q),
    .z_flag   (z_q),
    .state    (st),
    .pass     (cond_ok)
  );

  pred_cpu16_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .pc_step (fetching),
    .wr_en   (st == ST_EXEC),
    .wr_sel  (dst_sel),
    .wr_val  (alu_res),
    .ra_sel  (src_sel),
    .ra_val  (src_val),
    .rb_sel  (dst_sel),
    .rb_val  (dst_val),
    .pc_val  (pc_val)
  );

  pred_cpu16_alu #(.DW(DW)) u_alu (
    .op    (op),
    .a     (dst_val),
    .b     (opnd_q),
    .cin   (c_q),
    .res   (alu_res),
    .cout  (alu_cout),
    .zero  (alu_zero),
    .c_upd (alu_cupd),
    .z_upd (alu_zupd)
  );

  // Instruction and operand registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q   <= '0;
      opnd_q <= '0;
    end else begin
      case (st)
        ST_FETCH0: ir_q   <= bus_rdata;
        ST_FETCH1: opnd_q <= bus_rdata;
        ST_EA:     if (cond_ok) opnd_q <= src_val + ea_offs;
        ST_RDMEM:  opnd_q <= bus_rdata;
        default: ;
      endcase
    end
  end

  // Flags
  always_ff @(posedge clk) begin
    if (rst) begin
      c_q <= 1'b0;
      z_q <= 1'b0;
    end else if (st == ST_EXEC) begin
      if (alu_cupd) c_q <= alu_cout;
      if (alu_zupd) z_q <= alu_zero;
    end
  end

  // Bus outputs decoded from registered state
  assign bus_addr  = fetching ? pc_val : opnd_q;
  assign bus_rnw   = (st != ST_WRMEM);
  assign bus_wdata = (st == ST_WRMEM) ? dst_val : '0;

endmodule

// File: rtl/pred_cpu16_chk.sv
module pred_cpu16_chk
  import pred_cpu16_pkg::*;
#(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_rnw,
  input logic [DW-1:0] bus_rdata,
  input state_e        state,
  input logic          pass,
  input logic          c_q,
  input logic          z_q,
  input logic [DW-1:0] pc,
  input logic [DW-1:0] ir,
  input logic [DW-1:0] rs_val
);

  p_reset_clears_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (state == ST_FETCH0 && pc == '0 && !c_q && !z_q));

  p_write_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
    !bus_rnw |=> bus_rnw);

  p_write_after_access_r2: assert property (@(posedge clk) disable iff (rst)
    !bus_rnw |-> ($past(state) == ST_EA || $past(state) == ST_RDMEM));

  p_pc_step_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH0 || state == ST_FETCH1) |=> pc == $past(pc) + DW'(1));

  p_long_fetch_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH0 && bus_rdata[LEN_BIT]) |=> state == ST_FETCH1);

  p_fetch_known_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH0) |-> !$isunknown(bus_rdata));

  p_skip_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EA && !pass) |=> (state == ST_FETCH0 && $stable(c_q) && $stable(z_q)));

  p_zero_reg_r9: assert property (@(posedge clk) disable iff (rst)
    (ir[SRC_LO +: 4] == 4'd0) |-> rs_val == '0);

endmodule

bind pred_cpu16 pred_cpu16_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_rnw   (bus_rnw),
  .bus_rdata (bus_rdata),
  .state     (st),
  .pass      (cond_ok),
  .c_q       (c_q),
  .z_q       (z_q),
  .pc        (pc_val),
  .ir        (ir_q),
  .rs_val    (src_val)
);

// File: tb/pred_cpu16_test.sv
`timescale 1ns/1ps
module pred_cpu16_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_rdata;
  logic [15:0] bus_wdata;
  logic [15:0] bus_addr;
  logic        bus_rnw;

  logic [15:0] mem [256];
  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;
  int stray  = 0;
  int pw     = 0;

  always #4 clk = ~clk;

  pred_cpu16 uut (
    .clk(clk), .rst(rst), .bus_rdata(bus_rdata),
    .bus_wdata(bus_wdata), .bus_addr(bus_addr), .bus_rnw(bus_rnw)
  );

  assign bus_rdata = mem[bus_addr[7:0]];

  // Store capture away from the rising edge
  initial forever begin
    @(negedge clk);
    if (!bus_rnw) begin
      mem[bus_addr[7:0]] = bus_wdata;
      wr_cnt++;
      if (bus_addr < 16'h0080) stray++;
    end
  end

  function automatic logic [15:0] ins(int cnd, int len, int opc, int rs, int rd);
    return {cnd[2:0], len[0], opc[3:0], rs[3:0], rd[3:0]};
  endfunction

  task automatic put(input logic [15:0] w);
    mem[pw[7:0]] = w;
    pw++;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    pw = 0;
    wr_cnt = 0;
    stray = 0;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(input int cycles);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic halt();
    int h;
    h = pw;
    put(ins(0, 1, 0, 0, 15)); put(16'(h));
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  logic [15:0] vals [6] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};

  initial begin
    logic [15:0] tr_a [25];
    logic        tr_r [25];
    logic [15:0] tr_w [25];
    int first_wr;

    // ---------- timing / fetch trace (R1 R3 R11) ----------
    clear_mem();
    put(ins(0, 1, 0, 0, 1)); put(16'h0005);   // LD R1,#5
    put(ins(0, 0, 1, 1, 1));                  // ADD R1,R1 short
    put(ins(5, 1, 0, 0, 1)); put(16'h0077);   // never, long
    put(ins(5, 0, 0, 0, 1));                  // never, short
    put(ins(0, 1, 8, 0, 2)); put(16'h0090);   // LD R2,[0x90]
    put(ins(0, 1, 7, 0, 1)); put(16'h0080);   // STO R1,[0x80]
    halt();
    mem[8'h90] = 16'h4321;
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int n = 0; n < 25; n++) begin
      tr_a[n] = bus_addr; tr_r[n] = bus_rnw; tr_w[n] = bus_wdata;
      @(negedge clk);
    end
    chk("R1 addr after reset", tr_a[0], 16'h0000);
    chk("R1 rnw after reset", {15'd0, tr_r[0]}, 16'h0001);
    chk("R1 wdata after reset", tr_w[0], 16'h0000);
    chk("R3 second word addr", tr_a[1], 16'h0001);
    chk("R3 fetch addr c4", tr_a[4], 16'h0002);
    chk("R3 fetch addr c7", tr_a[7], 16'h0003);
    chk("R5 R11 long skip resumes", tr_a[10], 16'h0005);
    chk("R5 R11 short skip resumes", tr_a[12], 16'h0006);
    chk("R8 read addr", tr_a[15], 16'h0090);
    first_wr = -1;
    for (int n = 24; n >= 0; n--) if (!tr_r[n]) first_wr = n;
    chk("R11 first write cycle", 16'(first_wr), 16'd20);
    chk("R2 write addr", tr_a[20], 16'h0080);
    chk("R2 write data", tr_w[20], 16'd10);
    chk("R2 write one cycle", {15'd0, tr_r[21]}, 16'h0001);
    chk("R2 wdata idle", tr_w[21], 16'h0000);

    // mid-program reset (R1)
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 reset mid-run addr", bus_addr, 16'h0000);
    chk("R1 reset mid-run rnw", {15'd0, bus_rnw}, 16'h0001);

    // ---------- misc program (R4 R5 R8 R9 R10) ----------
    clear_mem();
    put(ins(0, 1, 0, 0, 5)); put(16'h0);
    put(ins(0, 1, 0, 0, 6)); put(16'h0);
    put(ins(0, 1, 0, 0, 9)); put(16'h0);
    put(ins(0, 1, 0, 0, 0)); put(16'h1234);   // write R0
    put(ins(0, 1, 7, 0, 0)); put(16'h0085);   // STO R0
    put(ins(5, 1, 0, 0, 5)); put(16'h0055);
    put(ins(6, 1, 0, 0, 5)); put(16'h0056);
    put(ins(7, 0, 0, 1, 6));
    put(ins(0, 1, 0, 0, 2)); put(16'h0007);
    put(ins(0, 1, 0, 0, 1)); put(16'h0005);
    put(ins(0, 0, 1, 2, 1));                  // ADD R1,R2 short -> 12
    put(ins(0, 1, 8, 2, 7)); put(16'h0089);   // R7 = mem[7+0x89]
    put(ins(0, 1, 15, 0, 7)); put(16'h0091);  // mem[mem[0x91]] = R7
    begin
      int pcat;
      int jat;
      pcat = pw;
      put(ins(0, 0, 0, 15, 8));               // R8 = R15
      jat = pw;
      put(ins(0, 1, 0, 0, 15)); put(16'(jat + 4));
      put(ins(0, 1, 0, 0, 9)); put(16'h0099); // jumped over
      put(ins(0, 1, 7, 0, 5)); put(16'h0086);
      put(ins(0, 1, 7, 0, 6)); put(16'h0087);
      put(ins(0, 1, 7, 0, 1)); put(16'h0088);
      put(ins(0, 1, 7, 0, 8)); put(16'h0089);
      put(ins(0, 1, 7, 0, 9)); put(16'h008A);
      halt();
      mem[8'h90] = 16'hBEEF;
      mem[8'h91] = 16'h00A0;
      run(140);
      chk("R9 zero reg store", mem[8'h85], 16'h0000);
      chk("R5 never 101/110", mem[8'h86], 16'h0000);
      chk("R5 never 111 short", mem[8'h87], 16'h0000);
      chk("R4 short source operand", mem[8'h88], 16'd12);
      chk("R10 pc as source", mem[8'h89], 16'(pcat + 1));
      chk("R10 jump skips", mem[8'h8A], 16'h0000);
      chk("R4 R8 indexed read to indirect store", mem[8'hA0], 16'hBEEF);
      chk("R2 store count", 16'(wr_cnt), 16'd7);
      chk("R2 no stray writes", 16'(stray), 16'd0);
    end

    // ---------- ALU / flag / condition sweep (R5 R6 R7) ----------
    for (int op = 0; op < 7; op++) begin
      for (int ia = 0; ia < 6; ia++) begin
        for (int ib = 0; ib < 6; ib++) begin
          for (int ci = 0; ci < 2; ci++) begin
            logic [15:0] a, b, r;
            logic [16:0] s;
            logic c, z;
            a = vals[ia]; b = vals[ib];
            c = ci[0]; z = 1'b1;
            case (op)
              0: r = b;
              1: begin s = {1'b0, a} + {1'b0, b}; r = s[15:0]; c = s[16]; end
              2: r = a & b;
              3: r = a | b;
              4: r = a ^ b;
              5: begin r = {ci[0], b[15:1]}; c = b[0]; end
              default: begin s = {1'b0, a} + {1'b0, b} + 17'(ci); r = s[15:0]; c = s[16]; end
            endcase
            if (op != 0) z = (r == 16'h0000);
            clear_mem();
            put(ins(0, 1, 0, 0, 3)); put(16'h0);
            put(ins(0, 1, 0, 0, 4)); put(16'h0);
            put(ins(0, 1, 0, 0, 5)); put(16'h0);
            put(ins(0, 1, 0, 0, 6)); put(16'h0);
            put(ins(0, 1, 0, 0, 1)); put(a);
            put(ins(0, 1, 5, 0, 2)); put(16'(ci));   // C = ci, Z = 1
            put(ins(0, 1, op, 0, 1)); put(b);
            put(ins(1, 1, 0, 0, 3)); put(16'h1);
            put(ins(2, 1, 0, 0, 5)); put(16'h1);
            put(ins(3, 1, 0, 0, 4)); put(16'h1);
            put(ins(4, 1, 0, 0, 6)); put(16'h1);
            put(ins(0, 1, 7, 0, 1)); put(16'h0080);
            put(ins(0, 1, 7, 0, 3)); put(16'h0081);
            put(ins(0, 1, 7, 0, 4)); put(16'h0082);
            put(ins(0, 1, 7, 0, 5)); put(16'h0083);
            put(ins(0, 1, 7, 0, 6)); put(16'h0084);
            halt();
            run(80);
            chk("R6 result", mem[8'h80], r);
            chk("R5 R7 carry-set cond", mem[8'h81], {15'd0, c});
            chk("R5 R7 carry-clear cond", mem[8'h83], {15'd0, !c});
            chk("R5 R7 zero-set cond", mem[8'h82], {15'd0, z});
            chk("R5 R7 zero-clear cond", mem[8'h84], {15'd0, !z});
            chk("R2 sweep store count", 16'(wr_cnt), 16'd5);
          end
        end
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule